// File: doc/BRIEF.md
# Clock Fan-out Enable Register Slave

This block is a two-wire serial slave, in the SMBus style, that holds the control bytes of a six-pair differential clock fan-out. SCL and SDA are oversampled on the core clock through synchronizers. Start, repeated start and stop are found from those samples. The slave pulls SDA low through an open-drain style enable and never drives it high. A decoded six-bit vector gates the output pairs, and the raw contents of all registers are also brought out.

A host reaches the registers through indexed block transfers. A write carries the start index, then a byte count, then the data. A read sets the index with a short write phase, then turns the bus around with a repeated start. The slave answers with the stored byte count, followed by data from the index upward, until the host refuses a byte.

Top module: `clkfan_cfg_slave`

## Requirements
- R1: After reset, register 1 holds 0x40 and registers 0 and 2 to 6 hold 0xFF. The stored byte count is 7 and all six pair enables are 1.
- R2: The slave acknowledges the address bytes 0xD4 (write) and 0xD5 (read), where bit 0 is the direction. Any other address byte is not acknowledged. After such a byte the slave leaves SDA released, including every later acknowledge slot, until the next start.
- R3: A write transfer is sent as 0xD4, index N, count X, then data. The slave acknowledges every byte. Data byte k is stored in register N+k, so the index advances by one after each data byte. All 8 bits of every implemented register, reserved bits included, are writable.
- R4: After the index is set, a repeated start and 0xD5 make the slave transmit the count byte first. It then sends the contents of registers N, N+1, N+2 and so on.
- R5: A host NACK on a transmitted byte ends the read. SDA stays released until the next start or stop.
- R6: Each pair enable is 1 when its bit is 1 and 0 when its bit is 0. The bit for each pair is fixed: pair 0 is register 0 bit 7, pair 1 is register 0 bit 6, pair 2 is register 0 bit 3, pair 3 is register 1 bit 6, pair 4 is register 0 bit 0, and pair 5 is register 0 bit 2.
- R7: Data written at an index of 7 or above is acknowledged and discarded. Reads at an index of 7 or above return 0x00.
- R8: The count byte sent on a read equals the count byte of the most recent write that reached its count phase. Before any such write it is 7.
- R9: If a stop or a start arrives part way through a byte, that partial byte is dropped. Bytes that were already acknowledged stay committed, and so does a new index or count.
- R10: Bytes are sent most significant bit first. The slave changes SDA only after SCL falls, or after a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pair_en | output | 6 | Enable per differential output pair, bit p for pair p |
| reg_flat | output | 56 | Register i in bits 8*i+7 down to 8*i |

## Verification
The hardest case to reach from the ports is a transfer cut off part way through a byte. The cut has to come after some bytes of the same transfer were committed and before the next byte finishes. The stimulus gets there by driving the bus bit by bit. It stops a write after four bits of its second data byte. It also breaks a write after three bits with a repeated start that goes straight into a read. That read shows the count and index that were kept and the register that was left untouched. A block write that starts near the top of the register range exercises the discarded tail and the zero-filled reads.

// File: rtl/fanout_cfg_pkg.sv
package fanout_cfg_pkg;

  localparam int NUM_PAIRS = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_TX,
    PH_IGNORE
  } phase_t;

  // Power-up contents: register 1 keeps only its enable bit set.
  function automatic logic [7:0] reg_reset_value(input int idx);
    return (idx == 1) ? 8'h40 : 8'hFF;
  endfunction

  // Register index advance, held at the top of the index space.
  function automatic logic [7:0] next_ptr(input logic [7:0] p);
    return (p == 8'hFF) ? p : p + 8'd1;
  endfunction

  // Bit selection for each output pair.
  function automatic logic [NUM_PAIRS-1:0] pair_enables(input logic [7:0] r0,
                                                        input logic [7:0] r1);
    logic [NUM_PAIRS-1:0] en;
    en[0] = r0[7];
    en[1] = r0[6];
    en[2] = r0[3];
    en[3] = r1[6];
    en[4] = r0[0];
    en[5] = r0[2];
    return en;
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import fanout_cfg_pkg::*;
#(
  parameter int NUM_REGS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  cnt_wr,
  input  logic [7:0]            cnt_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            count_q,
  output logic [NUM_REGS*8-1:0] reg_flat,
  output logic [NUM_PAIRS-1:0]  pair_en
);
  localparam logic [7:0] COUNT_RESET = 8'(NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= reg_reset_value(g);
      else if (wr_en && wr_idx == 8'(g))      q <= wr_data;
    end
    assign reg_flat[g*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= COUNT_RESET;
    else if (cnt_wr) count_q <= cnt_data;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == 8'(i)) rd_data = reg_flat[i*8 +: 8];
  end

  assign pair_en = pair_enables(reg_flat[7:0], reg_flat[15:8]);

  // R7
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_idx) < NUM_REGS);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cnt_wr) |=> ($stable(reg_flat) && $stable(count_q)));

endmodule

// File: rtl/txn_engine.sv
module txn_engine
  import fanout_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NUM_REGS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_s,
  input  logic [7:0] rd_data,
  input  logic [7:0] count_q,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       cnt_wr,
  output logic [7:0] cnt_data,
  output logic [7:0] rd_idx
);
  phase_t     ph, ph_nxt;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh, tx_sh, ptr;
  logic       host_ack, oe_q;

  wire active    = (ph != PH_IDLE) && (ph != PH_IGNORE);
  wire rx_phase  = active && (ph != PH_TX);
  wire byte_done = rx_phase && scl_fall && (bitcnt == 4'd8);
  wire addr_hit  = (rx_sh[7:1] == DEV_ADDR);
  wire in_range  = int'(ptr) < NUM_REGS;

  assign wr_en    = byte_done && (ph == PH_WDATA) && in_range;
  assign wr_idx   = ptr;
  assign wr_data  = rx_sh;
  assign cnt_wr   = byte_done && (ph == PH_COUNT);
  assign cnt_data = rx_sh;
  assign rd_idx   = ptr;
  assign sda_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      ph_nxt   <= PH_IDLE;
      bitcnt   <= 4'd0;
      rx_sh    <= 8'h00;
      tx_sh    <= 8'h00;
      ptr      <= 8'h00;
      host_ack <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_ev) begin
      ph     <= PH_ADDR;
      bitcnt <= 4'd0;
      oe_q   <= 1'b0;
    end else if (stop_ev) begin
      ph     <= PH_IDLE;
      bitcnt <= 4'd0;
      oe_q   <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8 && ph != PH_TX) rx_sh <= {rx_sh[6:0], sda_s};
        if (bitcnt == 4'd8 && ph == PH_TX) host_ack <= ~sda_s;
        if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (ph == PH_TX) begin
          if (bitcnt == 4'd9) begin
            if (host_ack) begin
              tx_sh  <= rd_data;
              oe_q   <= ~rd_data[7];
              ptr    <= next_ptr(ptr);
              bitcnt <= 4'd0;
            end else begin
              ph   <= PH_IGNORE;
              oe_q <= 1'b0;
            end
          end else if (bitcnt == 4'd8) begin
            oe_q <= 1'b0;
          end else if (bitcnt != 4'd0) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
            oe_q  <= ~tx_sh[6];
          end
        end else if (bitcnt == 4'd8) begin
          oe_q <= 1'b1;
          case (ph)
            PH_ADDR: begin
              if (addr_hit) ph_nxt <= rx_sh[0] ? PH_TX : PH_INDEX;
              else begin
                oe_q <= 1'b0;
                ph   <= PH_IGNORE;
              end
            end
            PH_INDEX: begin
              ptr    <= rx_sh;
              ph_nxt <= PH_COUNT;
            end
            PH_COUNT: ph_nxt <= PH_WDATA;
            PH_WDATA: begin
              ptr    <= next_ptr(ptr);
              ph_nxt <= PH_WDATA;
            end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          oe_q   <= 1'b0;
          bitcnt <= 4'd0;
          ph     <= ph_nxt;
          if (ph_nxt == PH_TX) begin
            tx_sh <= count_q;
            oe_q  <= ~count_q[7];
          end
        end
      end
    end
  end

  // R10
  oe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IGNORE) |-> !sda_oe);

  // R3
  wdata_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == PH_WDATA) |=> sda_oe);

  // R2
  addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == PH_ADDR && addr_hit) |=> sda_oe);

endmodule

// File: rtl/clkfan_cfg_slave.sv
module clkfan_cfg_slave
  import fanout_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         NUM_REGS    = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_PAIRS-1:0]  pair_en,
  output logic [NUM_REGS*8-1:0] reg_flat
);
  logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en, cnt_wr;
  logic [7:0] wr_idx, wr_data, cnt_data, rd_idx, rd_data, count_q;

  bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  txn_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_s    (sda_s),
    .rd_data  (rd_data),
    .count_q  (count_q),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cnt_wr   (cnt_wr),
    .cnt_data (cnt_data),
    .rd_idx   (rd_idx)
  );

  cfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cnt_wr   (cnt_wr),
    .cnt_data (cnt_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .count_q  (count_q),
    .reg_flat (reg_flat),
    .pair_en  (pair_en)
  );

endmodule

// File: tb/clkfan_cfg_slave_test.sv
`timescale 1ns/1ps
module clkfan_cfg_slave_test;
  localparam int NREG = 7;

  logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [5:0] pair_en;
  logic [NREG*8-1:0] reg_flat;
  wire sda_bus = sda_h & ~sda_oe;

  always #2.5 clk = ~clk;

  clkfan_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_oe(sda_oe), .pair_en(pair_en), .reg_flat(reg_flat)
  );

  int checks = 0, failures = 0;
  logic [7:0] shadow [NREG];
  logic [7:0] wbuf [8];
  logic [7:0] last_cnt;

  // {index, value}: single-byte writes walked in order
  localparam logic [15:0] VEC [8] = '{
    16'h00_7E, 16'h00_B3, 16'h01_00, 16'h01_FF,
    16'h03_5A, 16'h06_A5, 16'h07_C3, 16'h00_FF
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] model_en();
    logic [5:0] e;
    for (int p = 0; p < 6; p++) begin
      case (p)
        0: e[p] = shadow[0][7];
        1: e[p] = shadow[0][6];
        2: e[p] = shadow[0][3];
        3: e[p] = shadow[1][6];
        4: e[p] = shadow[0][0];
        default: e[p] = shadow[0][2];
      endcase
    end
    return e;
  endfunction

  function automatic logic [7:0] expect_at(input int a);
    return (a < NREG) ? shadow[a] : 8'h00;
  endfunction

  task automatic bus_start();
    sda_h = 1'b1; tick(4); scl_h = 1'b1; tick(8); sda_h = 1'b0; tick(8); scl_h = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(4); scl_h = 1'b1; tick(8); sda_h = 1'b1; tick(8);
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; tick(4); scl_h = 1'b1; tick(8); scl_h = 1'b0; tick(4);
  endtask

  task automatic recv_bit(output logic b);
    sda_h = 1'b1; tick(4); scl_h = 1'b1; tick(4); b = sda_bus; tick(4); scl_h = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic nb;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(nb);
    acked = ~nb;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~give_ack);
  endtask

  task automatic block_write(input logic [7:0] idx, input logic [7:0] cnt, input int n);
    logic a;
    bus_start();
    send_byte(8'hD4, a); check("R2 write address ack", a, 1);
    send_byte(idx, a);   check("R3 index ack", a, 1);
    send_byte(cnt, a);   check("R3 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      check("R3/R7 data ack", a, 1);
    end
    bus_stop();
    for (int i = 0; i < n; i++)
      if (int'(idx) + i < NREG) shadow[int'(idx) + i] = wbuf[i];
    last_cnt = cnt;
  endtask

  task automatic block_read(input logic [7:0] idx, input int n);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD4, a); check("R2 write address ack", a, 1);
    send_byte(idx, a);   check("R3 index ack", a, 1);
    bus_start();
    send_byte(8'hD5, a); check("R2 read address ack", a, 1);
    recv_byte(v, 1'b1);  check("R4/R8 count byte", v, last_cnt);
    for (int i = 0; i < n; i++) begin
      recv_byte(v, i != n - 1);
      check("R4/R7/R10 read data", v, expect_at(int'(idx) + i));
    end
    tick(2);
    check("R5 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    logic [63:0] flat_exp;
    for (int i = 0; i < NREG; i++) shadow[i] = (i == 1) ? 8'h40 : 8'hFF;
    last_cnt = 8'd7;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    flat_exp = '0;
    for (int i = 0; i < NREG; i++) flat_exp[i*8 +: 8] = shadow[i];
    check("R1 reset registers", {8'h00, reg_flat}, flat_exp);
    check("R1/R6 reset enables", pair_en, 6'h3F);
    check("R1 reset sda released", sda_oe, 0);
    block_read(8'h00, NREG);

    // R6 table walk: write one byte, read it back, check enables
    for (int k = 0; k < 8; k++) begin
      wbuf[0] = VEC[k][7:0];
      block_write(VEC[k][15:8], 8'd1, 1);
      block_read(VEC[k][15:8], 1);
      check("R6 pair enables", pair_en, model_en());
    end

    // R7 write running past the last register
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56; wbuf[3] = 8'h78;
    block_write(8'h05, 8'd4, 4);
    block_read(8'h05, 4);

    // R2 foreign address: no ack, line stays released
    bus_start();
    send_byte(8'hA0, a); check("R2 foreign address NACK", a, 0);
    send_byte(8'h00, a); check("R2 released after mismatch", a, 0);
    send_byte(8'h00, a); check("R2 released after mismatch", a, 0);
    bus_stop();
    check("R2 registers untouched", pair_en, model_en());
    block_read(8'h00, 2);

    // R9 stop in the middle of the second data byte
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h02, a); send_byte(8'h02, a);
    send_byte(8'h11, a); check("R9 first data ack", a, 1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    shadow[2] = 8'h11;
    last_cnt  = 8'd2;
    block_read(8'h02, 2);

    // R9 repeated start in the middle of a data byte, straight into a read
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h04, a); send_byte(8'h01, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hD5, a); check("R9 read after abort ack", a, 1);
    recv_byte(v, 1'b1);  check("R9/R8 count kept", v, 8'd1);
    recv_byte(v, 1'b0);  check("R9 partial byte dropped", v, shadow[4]);
    bus_stop();
    last_cnt = 8'd1;
    flat_exp = '0;
    for (int i = 0; i < NREG; i++) flat_exp[i*8 +: 8] = shadow[i];
    check("R9 raw registers", {8'h00, reg_flat}, flat_exp);

    tick(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule